// File: doc/BRIEF.md
# Flash Buffered-Write Staging Engine

This block stages a buffered program operation for an emulated parallel flash array. A start request snapshots one aligned write block from the main storage RAM into a local staging buffer. Data writes then land in that buffer instead of the array, and each one is checked against the block window. A commit copies the whole buffer back to the array. An abort drops the buffer and leaves the array as it was.

Command decoding and the status register are handled by the surrounding flash model. That model drives the four requests and reads back `busy_o`, `open_o` and `err_o`. The storage RAM sits outside the block and has a synchronous read with one cycle of latency. While no block is staged, data writes pass straight through to the RAM, so the engine can sit on the write path all the time.

Top module: `fbw_stage_engine`

## Requirements
- R1: After reset `busy_o`, `open_o` and `err_o` are 0, and `mem_we_o` and `mem_re_o` stay 0 while no request is presented.
- R2: The block size is 256 bytes for a 1-byte bank and 2048 bytes otherwise, multiplied by `DEVS`. The block base is the start address with its low log2(block size) bits cleared. Snapshot and commit both begin at word address base / `BANK_BYTES`.
- R3: A start that arrives while idle raises `busy_o` on the next cycle. The snapshot reads one RAM word per cycle, keeps `busy_o` high for block words + 1 cycles, writes nothing to the RAM, and then sets `open_o`.
- R4: While `open_o` is set, a write whose bytes all lie inside the block updates only the staging buffer, and the RAM is not touched. Byte i of a W-byte write goes to address A+i. It comes from value bits [8i+7:8i] when `BIG_ENDIAN`=0, and from bits [8(W-1-i)+7:8(W-1-i)] when `BIG_ENDIAN`=1.
- R5: While open, a write with A < base or A+W > base + block size is not stored, and `err_o` rises on the next cycle. `err_o` holds until the next accepted start clears it.
- R6: A commit while open raises `busy_o` on the next cycle and writes the buffer back, one full word per cycle with all byte enables set, for block-words cycles. The engine then returns to idle, and the array then holds the snapshot with every accepted staged write applied.
- R7: An abort while open returns the engine to idle on the next cycle, with no RAM write, and leaves the array unchanged.
- R8: While idle, a data write goes to the RAM in the same cycle. Address byte A+i sits in lane (A mod `BANK_BYTES`)+i, at bits [8·lane+7:8·lane], with only those byte enables set. The write must not cross a word boundary.
- R9: A start while open is ignored. Writes, starts, commits and aborts during `busy_o` are ignored. Commit and abort while idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin staging the block containing `start_addr_i` |
| start_addr_i | input | ADDR_W | Byte address used to select the block |
| wr_i | input | 1 | Data write request |
| wr_addr_i | input | ADDR_W | Byte address of the first written byte |
| wr_bytes_i | input | clog2(BANK_BYTES+1) | Number of bytes written, 1..BANK_BYTES |
| wr_data_i | input | 8·BANK_BYTES | Write value |
| commit_i | input | 1 | Copy the staged block back to the array |
| abort_i | input | 1 | Discard the staged block |
| mem_addr_o | output | ADDR_W-clog2(BANK_BYTES) | RAM word address |
| mem_re_o | output | 1 | RAM read strobe |
| mem_we_o | output | 1 | RAM write strobe |
| mem_be_o | output | BANK_BYTES | RAM byte-lane enables |
| mem_wdata_o | output | 8·BANK_BYTES | RAM write data |
| mem_rdata_i | input | 8·BANK_BYTES | RAM read data, one cycle after the read |
| busy_o | output | 1 | Snapshot or commit copy in progress |
| open_o | output | 1 | A block is staged and accepts writes |
| err_o | output | 1 | Sticky out-of-window programming error |

## Verification
A pass-through write reaches the RAM on the same clock edge that samples it. The window error appears one cycle after the rejected write. `busy_o` rises one cycle after a start or commit and then stays high for exactly block words + 1 or block words cycles. The bench drives every request on a falling edge and samples on the following falling edge, so each check sees the value registered by the single rising edge in between. The busy windows are counted edge by edge against those expected lengths, not polled open-endedly. Array contents are compared only after the commit or abort has fully settled.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SNAP   = 2'd1,
        ST_OPEN   = 2'd2,
        ST_COMMIT = 2'd3
    } fbw_state_e;

    // Staging block size in bytes for one bank configuration.
    function automatic int fbw_blk_bytes(int bank_bytes, int devs);
        return ((bank_bytes == 1) ? 256 : 2048) * devs;
    endfunction

endpackage

// File: rtl/fbw_window_chk.sv
module fbw_window_chk #(
    parameter int ADDR_W     = 13,
    parameter int BLK_BYTES  = 2048,
    parameter int BANK_BYTES = 2
) (
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [$clog2(BANK_BYTES+1)-1:0]    nbytes,
    input  logic [ADDR_W-1:0]                  base,
    output logic                               in_win,
    output logic [$clog2(BLK_BYTES)-1:0]       offset
);
    localparam int OFF_W = $clog2(BLK_BYTES);

    logic [ADDR_W:0] wr_end;
    logic [ADDR_W:0] win_end;

    always_comb begin
        wr_end  = {1'b0, addr} + (ADDR_W+1)'(nbytes);
        win_end = {1'b0, base} + (ADDR_W+1)'(BLK_BYTES);
        in_win  = (addr >= base) && (wr_end <= win_end);
        offset  = OFF_W'(addr - base);
    end
endmodule

// File: rtl/fbw_lane_map.sv
module fbw_lane_map #(
    parameter int ADDR_W     = 13,
    parameter int BANK_BYTES = 2,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic [$clog2(BANK_BYTES+1)-1:0] nbytes,
    input  logic [8*BANK_BYTES-1:0]         data,
    output logic [8*BANK_BYTES-1:0]         seq,
    output logic [8*BANK_BYTES-1:0]         lane_data,
    output logic [BANK_BYTES-1:0]           lane_be
);
    int lane;
    int nb;

    always_comb begin
        nb        = int'(nbytes);
        lane      = int'(addr) % BANK_BYTES;
        seq       = '0;
        lane_data = '0;
        lane_be   = '0;
        // seq byte i belongs at byte address addr+i
        for (int i = 0; i < BANK_BYTES; i++) begin
            if (i < nb) begin
                if (BIG_ENDIAN) seq[8*i +: 8] = data[8*(nb-1-i) +: 8];
                else            seq[8*i +: 8] = data[8*i +: 8];
            end
        end
        for (int i = 0; i < BANK_BYTES; i++) begin
            if (i < nb && (lane + i) < BANK_BYTES) begin
                lane_data[8*(lane+i) +: 8] = seq[8*i +: 8];
                lane_be[lane+i]            = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fbw_stage_buf.sv
module fbw_stage_buf #(
    parameter int BANK_BYTES = 2,
    parameter int BLK_BYTES  = 2048
) (
    input  logic                                        clk_i,
    input  logic                                        word_we,
    input  logic [$clog2(BLK_BYTES/BANK_BYTES)-1:0]     word_idx,
    input  logic [8*BANK_BYTES-1:0]                     word_data,
    input  logic                                        byte_we,
    input  logic [$clog2(BLK_BYTES)-1:0]                byte_off,
    input  logic [$clog2(BANK_BYTES+1)-1:0]             byte_n,
    input  logic [8*BANK_BYTES-1:0]                     byte_seq,
    input  logic [$clog2(BLK_BYTES/BANK_BYTES)-1:0]     rd_idx,
    output logic [8*BANK_BYTES-1:0]                     rd_data
);
    localparam int OFF_W = $clog2(BLK_BYTES);

    logic [7:0] store_q [BLK_BYTES];

    always_ff @(posedge clk_i) begin
        if (word_we) begin
            for (int l = 0; l < BANK_BYTES; l++)
                store_q[OFF_W'(int'(word_idx)*BANK_BYTES + l)] <= word_data[8*l +: 8];
        end
        if (byte_we) begin
            for (int i = 0; i < BANK_BYTES; i++)
                if (i < int'(byte_n))
                    store_q[byte_off + OFF_W'(i)] <= byte_seq[8*i +: 8];
        end
    end

    always_comb begin
        for (int l = 0; l < BANK_BYTES; l++)
            rd_data[8*l +: 8] = store_q[OFF_W'(int'(rd_idx)*BANK_BYTES + l)];
    end
endmodule

// File: rtl/fbw_stage_engine.sv
module fbw_stage_engine
    import fbw_pkg::*;
#(
    parameter int BANK_BYTES = 2,
    parameter int DEVS       = 1,
    parameter int ADDR_W     = 13,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                                     clk_i,
    input  logic                                     rst_ni,
    input  logic                                     start_i,
    input  logic [ADDR_W-1:0]                        start_addr_i,
    input  logic                                     wr_i,
    input  logic [ADDR_W-1:0]                        wr_addr_i,
    input  logic [$clog2(BANK_BYTES+1)-1:0]          wr_bytes_i,
    input  logic [8*BANK_BYTES-1:0]                  wr_data_i,
    input  logic                                     commit_i,
    input  logic                                     abort_i,
    output logic [ADDR_W-$clog2(BANK_BYTES)-1:0]     mem_addr_o,
    output logic                                     mem_re_o,
    output logic                                     mem_we_o,
    output logic [BANK_BYTES-1:0]                    mem_be_o,
    output logic [8*BANK_BYTES-1:0]                  mem_wdata_o,
    input  logic [8*BANK_BYTES-1:0]                  mem_rdata_i,
    output logic                                     busy_o,
    output logic                                     open_o,
    output logic                                     err_o
);
    localparam int DW        = 8*BANK_BYTES;
    localparam int BLK_BYTES = fbw_blk_bytes(BANK_BYTES, DEVS);
    localparam int BLK_WORDS = BLK_BYTES / BANK_BYTES;
    localparam int WIDX_W    = $clog2(BLK_WORDS);
    localparam int OFF_W     = $clog2(BLK_BYTES);
    localparam int LSH       = $clog2(BANK_BYTES);
    localparam int MA_W      = ADDR_W - LSH;
    localparam logic [WIDX_W-1:0] LAST_IDX  = WIDX_W'(BLK_WORDS-1);
    localparam logic [ADDR_W-1:0] BASE_MASK = ~ADDR_W'(BLK_BYTES-1);

    typedef struct packed {
        fbw_state_e          st;
        logic [ADDR_W-1:0]   base;
        logic [WIDX_W-1:0]   cnt;      // issue / commit word index
        logic                cap_vld;  // RAM data for cap_idx arrives this cycle
        logic [WIDX_W-1:0]   cap_idx;
        logic                err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              win_ok;
    logic [OFF_W-1:0]  win_off;
    logic [DW-1:0]     wr_seq, wr_lane_data, buf_rdata;
    logic [BANK_BYTES-1:0] wr_lane_be;
    logic              stage_we;
    logic [MA_W-1:0]   base_word;

    fbw_window_chk #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .BANK_BYTES(BANK_BYTES)) u_win (
        .addr(wr_addr_i), .nbytes(wr_bytes_i), .base(ctl_q.base),
        .in_win(win_ok), .offset(win_off)
    );

    fbw_lane_map #(.ADDR_W(ADDR_W), .BANK_BYTES(BANK_BYTES), .BIG_ENDIAN(BIG_ENDIAN)) u_map (
        .addr(wr_addr_i), .nbytes(wr_bytes_i), .data(wr_data_i),
        .seq(wr_seq), .lane_data(wr_lane_data), .lane_be(wr_lane_be)
    );

    fbw_stage_buf #(.BANK_BYTES(BANK_BYTES), .BLK_BYTES(BLK_BYTES)) u_buf (
        .clk_i(clk_i),
        .word_we(ctl_q.cap_vld), .word_idx(ctl_q.cap_idx), .word_data(mem_rdata_i),
        .byte_we(stage_we), .byte_off(win_off), .byte_n(wr_bytes_i), .byte_seq(wr_seq),
        .rd_idx(ctl_q.cnt), .rd_data(buf_rdata)
    );

    assign base_word = ctl_q.base[ADDR_W-1:LSH];

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.cap_vld = 1'b0;
        mem_addr_o    = '0;
        mem_re_o      = 1'b0;
        mem_we_o      = 1'b0;
        mem_be_o      = '0;
        mem_wdata_o   = '0;
        stage_we      = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (wr_i) begin                    // pass-through to storage
                    mem_we_o    = 1'b1;
                    mem_be_o    = wr_lane_be;
                    mem_wdata_o = wr_lane_data;
                    mem_addr_o  = wr_addr_i[ADDR_W-1:LSH];
                end
                if (start_i) begin
                    ctl_d.st   = ST_SNAP;
                    ctl_d.base = start_addr_i & BASE_MASK;
                    ctl_d.cnt  = '0;
                    ctl_d.err  = 1'b0;
                end
            end
            ST_SNAP: begin
                if (ctl_q.cap_vld && ctl_q.cap_idx == LAST_IDX) begin
                    ctl_d.st = ST_OPEN;
                end else begin
                    mem_re_o      = 1'b1;
                    mem_addr_o    = base_word + MA_W'(ctl_q.cnt);
                    ctl_d.cap_vld = 1'b1;
                    ctl_d.cap_idx = ctl_q.cnt;
                    ctl_d.cnt     = ctl_q.cnt + WIDX_W'(1);
                end
            end
            ST_OPEN: begin
                if (abort_i) begin
                    ctl_d.st = ST_IDLE;
                end else if (commit_i) begin
                    ctl_d.st  = ST_COMMIT;
                    ctl_d.cnt = '0;
                end else if (wr_i) begin
                    if (win_ok) stage_we  = 1'b1;
                    else        ctl_d.err = 1'b1;
                end
            end
            ST_COMMIT: begin
                mem_we_o    = 1'b1;
                mem_be_o    = '1;
                mem_addr_o  = base_word + MA_W'(ctl_q.cnt);
                mem_wdata_o = buf_rdata;
                if (ctl_q.cnt == LAST_IDX) ctl_d.st  = ST_IDLE;
                else                       ctl_d.cnt = ctl_q.cnt + WIDX_W'(1);
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign busy_o = (ctl_q.st == ST_SNAP) || (ctl_q.st == ST_COMMIT);
    assign open_o = (ctl_q.st == ST_OPEN);
    assign err_o  = ctl_q.err;
endmodule

// File: rtl/fbw_stage_engine_chk.sv
module fbw_stage_engine_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic wr_i,
    input logic commit_i,
    input logic abort_i,
    input logic mem_re_o,
    input logic mem_we_o,
    input logic busy_o,
    input logic open_o,
    input logic err_o
);
    p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && !open_o) |=> busy_o)
        else $error("R3: start while idle did not raise busy");

    p_open_after_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(open_o) |-> $past(busy_o))
        else $error("R3: open without a preceding snapshot");

    p_open_no_ram_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        open_o |-> (!mem_we_o && !mem_re_o))
        else $error("R4: RAM accessed while block is open");

    p_err_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> $past(wr_i && open_o))
        else $error("R5: error raised without an open-state write");

    p_err_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(err_o) |-> $past(start_i))
        else $error("R5: error cleared without a start");

    p_commit_go_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_i && open_o && !abort_i) |=> (busy_o && mem_we_o))
        else $error("R6: commit did not begin write-back");

    p_abort_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (abort_i && open_o) |=> (!open_o && !busy_o && !mem_we_o))
        else $error("R7: abort did not return quietly to idle");
endmodule

bind fbw_stage_engine fbw_stage_engine_chk u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .wr_i(wr_i),
    .commit_i(commit_i), .abort_i(abort_i), .mem_re_o(mem_re_o),
    .mem_we_o(mem_we_o), .busy_o(busy_o), .open_o(open_o), .err_o(err_o)
);

// File: tb/fbw_stage_engine_test.sv
`timescale 1ns/1ps
module fbw_stage_engine_test;
    localparam int B      = 2;
    localparam int AW     = 13;
    localparam int NBYTES = 1 << AW;
    localparam int NWORDS = NBYTES / B;
    localparam int BLKW   = 2048 / B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start, wr, commit, abort_r;
    logic [AW-1:0] start_addr, wr_addr;
    logic [1:0]    wr_bytes;
    logic [15:0]   wr_data;
    logic [11:0]   mem_addr;
    logic          mem_re, mem_we, busy, open_s, err;
    logic [1:0]    mem_be;
    logic [15:0]   mem_wdata, mem_rdata;

    fbw_stage_engine #(.BANK_BYTES(B), .DEVS(1), .ADDR_W(AW), .BIG_ENDIAN(1'b0)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
        .wr_i(wr), .wr_addr_i(wr_addr), .wr_bytes_i(wr_bytes), .wr_data_i(wr_data),
        .commit_i(commit), .abort_i(abort_r), .mem_addr_o(mem_addr), .mem_re_o(mem_re),
        .mem_we_o(mem_we), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .busy_o(busy), .open_o(open_s), .err_o(err)
    );

    function automatic logic [7:0] pat(int a);
        return 8'(a*7 + 3);
    endfunction

    // storage RAM model, synchronous read
    logic [15:0] ram [NWORDS];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWORDS; w++) ram[w] <= {pat(2*w+1), pat(2*w)};
            mem_rdata <= '0;
        end else begin
            if (mem_we) begin
                for (int l = 0; l < B; l++)
                    if (mem_be[l]) ram[mem_addr][8*l +: 8] <= mem_wdata[8*l +: 8];
            end
            mem_rdata <= ram[mem_addr];
        end
    end

    function automatic logic [7:0] rdbyte(int a);
        return ram[a/B][8*(a%B) +: 8];
    endfunction

    logic [7:0] exp_b [NBYTES];
    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<=200000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    typedef struct packed {
        logic [AW-1:0] a;
        logic [1:0]    n;
        logic [15:0]   v;
        logic          e;
    } vec_t;

    // staged writes against the block at 0x800 (R4, R5)
    localparam vec_t VECS [7] = '{
        '{13'h0800, 2'd2, 16'h1234, 1'b0},
        '{13'h0FFF, 2'd1, 16'h00AB, 1'b0},
        '{13'h0FFF, 2'd2, 16'hCDEF, 1'b1},
        '{13'h07FF, 2'd1, 16'h0011, 1'b1},
        '{13'h0A37, 2'd2, 16'h7788, 1'b0},
        '{13'h0000, 2'd2, 16'h9999, 1'b1},
        '{13'h0FFE, 2'd2, 16'h5566, 1'b0}
    };

    task automatic idle_inputs();
        start = 0; wr = 0; commit = 0; abort_r = 0;
        start_addr = '0; wr_addr = '0; wr_bytes = '0; wr_data = '0;
    endtask

    task automatic pulse_write(int a, int n, int v);
        wr = 1; wr_addr = AW'(a); wr_bytes = 2'(n); wr_data = 16'(v);
        @(negedge clk);
        wr = 0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 5000) begin n++; @(negedge clk); end
    endtask

    initial begin
        int n;
        int mism;
        bit e_acc;
        idle_inputs();
        for (int a = 0; a < NBYTES; a++) exp_b[a] = pat(a);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check(!busy && !open_s && !err, "R1 flags after reset", {busy, open_s, err}, 0);
        check(!mem_we && !mem_re, "R1 no RAM access", {mem_we, mem_re}, 0);

        // R8 pass-through writes while idle
        pulse_write(13'h0804, 2, 16'hBEEF);
        exp_b[13'h804] = 8'hEF; exp_b[13'h805] = 8'hBE;
        check(rdbyte(13'h804) == 8'hEF && rdbyte(13'h805) == 8'hBE, "R8 direct word",
              {rdbyte(13'h805), rdbyte(13'h804)}, 16'hBEEF);
        wr = 1; wr_addr = 13'h0807; wr_bytes = 2'd1; wr_data = 16'h005A;
        @(posedge clk); #1;
        check(mem_we && mem_be == 2'b10 && mem_wdata[15:8] == 8'h5A, "R8 odd lane",
              {mem_be, mem_wdata}, {2'b10, 16'h5A00});
        @(negedge clk); wr = 0;
        exp_b[13'h807] = 8'h5A;
        check(rdbyte(13'h806) == pat(13'h806) && rdbyte(13'h807) == 8'h5A, "R8 lane enables",
              {rdbyte(13'h807), rdbyte(13'h806)}, {8'h5A, pat(13'h806)});

        // R2/R3 snapshot of block at 0x800 from an unaligned start address
        start = 1; start_addr = 13'h0A37;
        @(negedge clk); start = 0;
        check(busy && mem_re && mem_addr == 12'h400, "R2 first snapshot word",
              {busy, mem_re, mem_addr}, {2'b11, 12'h400});
        // R9: a write during the snapshot is ignored
        repeat (5) @(negedge clk);
        pulse_write(13'h0900, 1, 16'h00EE);
        count_busy(n);
        check(n == BLKW + 1 - 6, "R3 snapshot busy length", n + 6, BLKW + 1);
        check(open_s && !busy, "R3 open after snapshot", open_s, 1);

        // R4/R5 vector walk
        e_acc = 0;
        for (int k = 0; k < 7; k++) begin
            pulse_write(int'(VECS[k].a), int'(VECS[k].n), int'(VECS[k].v));
            e_acc |= VECS[k].e;
            if (!VECS[k].e) begin
                for (int i = 0; i < int'(VECS[k].n); i++)
                    exp_b[int'(VECS[k].a) + i] = VECS[k].v[8*i +: 8];
            end
            check(err == e_acc, $sformatf("R5 err after vector %0d", k), err, e_acc);
            if (k == 0)
                check(rdbyte(13'h800) == pat(13'h800), "R4 array untouched while open",
                      rdbyte(13'h800), pat(13'h800));
        end

        // R9: start while open ignored
        start = 1; start_addr = 13'h0000;
        @(negedge clk); start = 0;
        check(open_s && !busy, "R9 start while open ignored", {open_s, busy}, 2'b10);

        // R6 commit
        commit = 1;
        @(negedge clk); commit = 0;
        check(busy && mem_we && mem_addr == 12'h400 && mem_be == 2'b11, "R6 first commit word",
              {mem_we, mem_be, mem_addr}, {1'b1, 2'b11, 12'h400});
        count_busy(n);
        check(n == BLKW, "R6 commit busy length", n, BLKW);
        check(!open_s && !busy, "R6 idle after commit", {open_s, busy}, 0);
        mism = 0;
        for (int a = 0; a < NBYTES; a++) if (rdbyte(a) != exp_b[a]) mism++;
        check(mism == 0, "R6 array after commit", mism, 0);
        check(rdbyte(13'h0A37) == 8'h88 && rdbyte(13'h0A38) == 8'h77, "R4 little-endian order",
              {rdbyte(13'h0A38), rdbyte(13'h0A37)}, 16'h7788);

        // R5 clear on start, R2 base of block 0, R7 abort
        start = 1; start_addr = 13'h0010;
        @(negedge clk); start = 0;
        check(!err, "R5 err cleared by start", err, 0);
        check(mem_re && mem_addr == 12'h000, "R2 base of block 0", mem_addr, 0);
        count_busy(n);
        pulse_write(13'h0004, 2, 16'h4321);
        abort_r = 1;
        @(negedge clk); abort_r = 0;
        check(!open_s && !busy && !mem_we, "R7 idle after abort", {open_s, busy, mem_we}, 0);
        check(rdbyte(4) == pat(4) && rdbyte(5) == pat(5), "R7 array unchanged",
              {rdbyte(5), rdbyte(4)}, {pat(5), pat(4)});

        // R9: commit/abort while idle ignored
        commit = 1;
        @(negedge clk); commit = 0;
        check(!busy && !mem_we && !open_s, "R9 commit while idle ignored", {busy, mem_we}, 0);
        abort_r = 1;
        @(negedge clk); abort_r = 0;
        check(!busy && !open_s, "R9 abort while idle ignored", {busy, open_s}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule